// File: doc/BRIEF.md
# Hardware Breakpoint Comparator

This block watches the instruction-execution side of a CPU bus and raises a break request when a programmed program-counter condition is met. It has four independent channels. Each channel holds a compare address, an address mask and a control word. Software loads these through a small synchronous register port, which also reads back a sticky per-channel match flag.

A channel is armed only for program-counter breaks. It compares the bus address with its own address, leaving out the masked bits. It then qualifies the hit with the execution-confirmed strobe, the first-address-of-instruction flag and the read strobe. A hit is dropped when the instruction sits in a delay slot or the chip is in a standby state.

A hit sets the channel's flag and pulses the break request one cycle later. In the same cycle it holds back a maskable interrupt that arrives in that cycle. A flag clears only through a handshake: software reads the flag register while the flag is 1, then writes 0 to that bit.

Top module: `brk_unit`

## Requirements
- R1: Register map on `reg_addr_i`. Channel n (0..3) has its address at n*4+0, its mask at n*4+1 and its control word at n*4+2. The flag register is at 16, with channel n at bit n. Every register reads back on `reg_rdata_o` in the same cycle, and all of them reset to 0.
- R2: A mask bit of 1 removes the matching address bit from the compare. Unmasked bits must be equal for a hit.
- R3: The control word holds a cycle field in bits [2:0], a PC field in bits [4:3] and a read field in bits [6:5]. A channel compares only when bit 0, bit 3 and bit 5 are all 1. Any other setting, including a zero field, never hits.
- R4: A hit needs `exec_ok_i`, `first_addr_i` and `read_i` all high in the same cycle as the address match.
- R5: A hit is suppressed while `delay_slot_i` is high.
- R6: No hit is detected while `standby_i` is high.
- R7: A hit sets the channel's flag on the next clock edge. The flag stays set after the condition goes away.
- R8: A flag bit clears only on a write of 0 to the flag register after a read that saw that bit as 1. Without such a read, a write of 0 leaves the bit set. A write of 1 never clears it. Any write to the flag register cancels the pending read state.
- R9: A new hit on a channel between the read and the write cancels that channel's pending read state, so the following write of 0 leaves the flag set.
- R10: `brk_req_o` is a one-cycle pulse on the edge after a cycle in which any channel hits. Several channels hitting together give one pulse.
- R11: `irq_pass_o` is `irq_req_i` registered by one cycle. It is forced low when a break hit occurs in the same cycle, so it is never high together with `brk_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr_i | input | 5 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| bus_addr_i | input | 24 | Instruction address on the bus |
| exec_ok_i | input | 1 | Fetch and execution confirmed |
| first_addr_i | input | 1 | Address is an instruction's first address |
| delay_slot_i | input | 1 | Instruction is in a delay slot |
| read_i | input | 1 | Read access strobe |
| standby_i | input | 1 | Chip is in a standby or sleep state |
| irq_req_i | input | 1 | Incoming maskable interrupt request |
| flag_o | output | 4 | Sticky per-channel match flags |
| brk_req_o | output | 1 | Break request pulse |
| irq_pass_o | output | 1 | Maskable interrupt allowed through |

## Verification
A wrong compare or qualification term shows on the next edge in two ways: as a missing or extra `brk_req_o` pulse, and as a flag bit that differs from the predicted set. The predicted set is known for every bus cycle. Faults in the read-then-write clearing stay hidden until the flag register is read back after the write. Each handshake variant is therefore followed by such a read within two cycles. A stuck flag or a lost arm state then shows as a single wrong bit.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef struct packed {
    logic [1:0] rd;
    logic [1:0] pc;
    logic [2:0] cyc;
  } brk_ctrl_t;
  localparam int unsigned CTRL_W = $bits(brk_ctrl_t);
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned AW     = 24,
  parameter int unsigned DW     = 32,
  parameter int unsigned RAW    = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [RAW-1:0]                     addr_i,
  input  logic [DW-1:0]                      wdata_i,
  output logic [NUM_CH-1:0][AW-1:0]          bar_o,
  output logic [NUM_CH-1:0][AW-1:0]          mask_o,
  output brk_pkg::brk_ctrl_t [NUM_CH-1:0]    ctrl_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [RAW-1:0] BASE = RAW'(c * 4);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bar_o[c]  <= '0;
        mask_o[c] <= '0;
        ctrl_o[c] <= '0;
      end else if (we_i) begin
        if (addr_i == BASE)      bar_o[c]  <= wdata_i[AW-1:0];
        if (addr_i == BASE + 1)  mask_o[c] <= wdata_i[AW-1:0];
        if (addr_i == BASE + 2)  ctrl_o[c] <= wdata_i[brk_pkg::CTRL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int unsigned AW = 24
) (
  input  logic [AW-1:0]        bar_i,
  input  logic [AW-1:0]        mask_i,
  input  brk_pkg::brk_ctrl_t   ctrl_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic                 exec_ok_i,
  input  logic                 first_addr_i,
  input  logic                 delay_slot_i,
  input  logic                 read_i,
  input  logic                 standby_i,
  output logic                 hit_o
);
  logic armed, addr_eq, qual;
  // only the PC-break setting compares; zero fields fall out automatically
  assign armed   = ctrl_i.cyc[0] & ctrl_i.pc[0] & ctrl_i.rd[0];
  assign addr_eq = ~|((bus_addr_i ^ bar_i) & ~mask_i);
  assign qual    = exec_ok_i & first_addr_i & read_i & ~delay_slot_i & ~standby_i;
  assign hit_o   = armed & addr_eq & qual;
endmodule

// File: rtl/brk_flags.sv
module brk_flags #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] flag_o
);
  logic [NUM_CH-1:0] arm_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[c] <= 1'b0;
        arm_q[c]  <= 1'b0;
      end else if (hit_i[c]) begin
        flag_o[c] <= 1'b1;
        arm_q[c]  <= 1'b0;
      end else if (wr_i) begin
        if (arm_q[c] && !wdata_i[c]) flag_o[c] <= 1'b0;
        arm_q[c] <= 1'b0;
      end else if (rd_i && flag_o[c]) begin
        arm_q[c] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned AW     = 24,
  parameter int unsigned DW     = 32,
  parameter int unsigned RAW    = $clog2(NUM_CH * 4 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [RAW-1:0]    reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              exec_ok_i,
  input  logic              first_addr_i,
  input  logic              delay_slot_i,
  input  logic              read_i,
  input  logic              standby_i,
  input  logic              irq_req_i,
  output logic [NUM_CH-1:0] flag_o,
  output logic              brk_req_o,
  output logic              irq_pass_o
);
  import brk_pkg::*;
  localparam logic [RAW-1:0] FLAG_OFS = RAW'(NUM_CH * 4);

  logic [NUM_CH-1:0][AW-1:0] bar, mask;
  brk_ctrl_t [NUM_CH-1:0]    ctrl;
  logic [NUM_CH-1:0]         hit;
  logic                      flag_sel;

  assign flag_sel = (reg_addr_i == FLAG_OFS);

  brk_regs #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW), .RAW(RAW)) i_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .bar_o(bar), .mask_o(mask), .ctrl_o(ctrl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    brk_cmp #(.AW(AW)) i_cmp (
      .bar_i(bar[c]), .mask_i(mask[c]), .ctrl_i(ctrl[c]), .bus_addr_i,
      .exec_ok_i, .first_addr_i, .delay_slot_i, .read_i, .standby_i,
      .hit_o(hit[c])
    );
  end

  brk_flags #(.NUM_CH(NUM_CH)) i_flags (
    .clk_i, .rst_ni, .hit_i(hit),
    .rd_i(reg_re_i & flag_sel), .wr_i(reg_we_i & flag_sel),
    .wdata_i(reg_wdata_i[NUM_CH-1:0]), .flag_o
  );

  always_comb begin
    reg_rdata_o = '0;
    if (flag_sel) reg_rdata_o[NUM_CH-1:0] = flag_o;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr_i == RAW'(c * 4))     reg_rdata_o[AW-1:0] = bar[c];
      if (reg_addr_i == RAW'(c * 4 + 1)) reg_rdata_o[AW-1:0] = mask[c];
      if (reg_addr_i == RAW'(c * 4 + 2)) reg_rdata_o[CTRL_W-1:0] = ctrl[c];
    end
  end

  // break beats a maskable interrupt arriving in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_req_o  <= 1'b0;
      irq_pass_o <= 1'b0;
    end else begin
      brk_req_o  <= |hit;
      irq_pass_o <= irq_req_i & ~|hit;
    end
  end
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RAW    = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [RAW-1:0]    reg_addr_i,
  input logic              exec_ok_i,
  input logic              first_addr_i,
  input logic              delay_slot_i,
  input logic              read_i,
  input logic              standby_i,
  input logic [NUM_CH-1:0] flag_o,
  input logic              brk_req_o,
  input logic              irq_pass_o
);
  localparam logic [RAW-1:0] FLAG_OFS = RAW'(NUM_CH * 4);

  AST_BRK_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> !irq_pass_o); // R11
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !brk_req_o); // R6
  AST_DSLOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_slot_i |=> !brk_req_o); // R5
  AST_REQ_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_ok_i || !first_addr_i || !read_i) |=> !brk_req_o); // R4
  AST_REQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> (flag_o != '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == FLAG_OFS) |=> ((flag_o & $past(flag_o)) == $past(flag_o))); // R8
endmodule

bind brk_unit brk_unit_chk #(.NUM_CH(NUM_CH), .RAW(RAW)) i_brk_unit_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .exec_ok_i(exec_ok_i), .first_addr_i(first_addr_i), .delay_slot_i(delay_slot_i),
  .read_i(read_i), .standby_i(standby_i), .flag_o(flag_o),
  .brk_req_o(brk_req_o), .irq_pass_o(irq_pass_o)
);

// File: tb/test_brk_unit.sv
module test_brk_unit;
  logic        clk = 0, rst_n = 0;
  logic        we = 0, re = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [23:0] bus_addr = 0;
  logic        ex = 0, fa = 0, ds = 0, rd = 0, sb = 0, iq = 0;
  logic [3:0]  flag;
  logic        brk, ipass;

  int n_run = 0, n_fail = 0;
  logic [3:0] exp_flag = 0;

  typedef struct { logic req; logic irq; logic [3:0] flags; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  brk_unit i_brk_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_addr_i(bus_addr), .exec_ok_i(ex),
    .first_addr_i(fa), .delay_slot_i(ds), .read_i(rd), .standby_i(sb), .irq_req_i(iq),
    .flag_o(flag), .brk_req_o(brk), .irq_pass_o(ipass)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); re = 1; addr = a;
    #1 check(tag, rdata, exp);
    @(negedge clk); re = 0;
  endtask

  // driver: one bus cycle, expected result pushed for the monitor
  task automatic bus(input logic [23:0] a, input logic e, f, d, r, s, i,
                     input logic [3:0] hit, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; ex = e; fa = f; ds = d; rd = r; sb = s; iq = i;
    exp_flag = exp_flag | hit;
    it.req = |hit; it.irq = i & ~|hit; it.flags = exp_flag; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    ex = 0; fa = 0; ds = 0; rd = 0; sb = 0; iq = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({it.tag, " req"}, {31'd0, brk}, {31'd0, it.req});
      check({it.tag, " irq"}, {31'd0, ipass}, {31'd0, it.irq});
      check({it.tag, " flags"}, {28'd0, flag}, {28'd0, it.flags});
    end
  end

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flags", {28'd0, flag}, 0);
    check("R10 reset req", {31'd0, brk}, 0);
    check("R11 reset irq", {31'd0, ipass}, 0);
    rst_n = 1;
    rd_chk(5'd2, 0, "R1 reset ctrl A");

    wr(5'd0, 32'h001000); wr(5'd1, 0);       wr(5'd2, 32'h29);
    wr(5'd4, 32'h002000); wr(5'd5, 32'hFF);  wr(5'd6, 32'h29);
    wr(5'd8, 32'h003000); wr(5'd10, 32'h28); // cycle field zero
    wr(5'd12, 32'h004000); wr(5'd14, 32'h52); // fields set but bit0 clear
    rd_chk(5'd0, 32'h001000, "R1 addr A");
    rd_chk(5'd5, 32'hFF, "R1 mask B");
    rd_chk(5'd14, 32'h52, "R1 ctrl D");

    bus(24'h001000, 1,1,0,1,0,0, 4'b0001, "R4 R10 hit A");
    bus(24'h001000, 0,0,0,0,0,0, 4'b0000, "R7 R10 sticky idle");
    bus(24'h0020A5, 1,1,0,1,0,0, 4'b0010, "R2 masked hit B");
    bus(24'h002100, 1,1,0,1,0,0, 4'b0000, "R2 unmasked miss");
    bus(24'h003000, 1,1,0,1,0,0, 4'b0000, "R3 zero field C");
    bus(24'h004000, 1,1,0,1,0,0, 4'b0000, "R3 bit0 clear D");
    bus(24'h001000, 1,0,0,1,0,0, 4'b0000, "R4 not first addr");
    bus(24'h001000, 0,1,0,1,0,0, 4'b0000, "R4 not executed");
    bus(24'h001000, 1,1,0,0,0,0, 4'b0000, "R4 no read");
    bus(24'h001000, 1,1,1,1,0,0, 4'b0000, "R5 delay slot");
    bus(24'h001000, 1,1,0,1,1,0, 4'b0000, "R6 standby");

    wr(5'd16, 0);
    rd_chk(5'd16, 32'h3, "R8 write0 without read");
    wr(5'd16, 0);
    exp_flag = 0;
    rd_chk(5'd16, 32'h0, "R8 read then write0 clears");

    bus(24'h001000, 1,1,0,1,0,0, 4'b0001, "R10 rehit A");
    rd_chk(5'd16, 32'h1, "R9 read armed");
    bus(24'h001000, 1,1,0,1,0,0, 4'b0001, "R9 new hit");
    wr(5'd16, 0);
    rd_chk(5'd16, 32'h1, "R9 write0 after new hit");
    wr(5'd16, 32'h1);
    rd_chk(5'd16, 32'h1, "R8 write1 keeps");
    wr(5'd16, 0);
    exp_flag = 0;
    rd_chk(5'd16, 32'h0, "R8 clear after second read");

    wr(5'd4, 32'h001000);
    bus(24'h0010FF, 1,1,0,1,0,0, 4'b0010, "R2 B mask only");
    bus(24'h001000, 1,1,0,1,0,1, 4'b0011, "R10 R11 dual hit with irq");
    bus(24'h000000, 0,0,0,0,0,1, 4'b0000, "R11 irq passes");
    bus(24'h000000, 0,0,0,0,0,0, 4'b0000, "R10 pulse ended");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule